// File: doc/BRIEF.md
# Timed Serial Loader for Latched Driver Chains

This block sits on the host side of a chain of cascaded serial-input latched output drivers, such as those used for vacuum-fluorescent display grids. When idle, it accepts a parallel word and a start request. It then shifts the word out one bit at a time on a serial clock it generates itself, sending the bit meant for the farthest output first. After the last bit it pulses the latch strobe, so the new pattern reaches all outputs together.

Every inter-signal timing is given as a parameter in nanoseconds. At elaboration each one is turned into a count of system-clock cycles, rounded up. The timings are data setup before the serial clock rises, serial clock high width, data hold after the serial clock falls, the gap before the strobe, and the strobe width. Each is enforced by its own count.

A request flag can raise blanking around the strobe, which dims the digits between multiplexed updates. A build-time variant serves boards where the latches are bypassed. In that variant the strobe line stays high, and blanking covers the whole time data is entered. A busy level and a one-cycle done pulse let the caller sequence frames.

Top module: `serial_drv_loader`

## Requirements
- R1: After reset `ser_clk`, `ser_data`, `blank_out`, `busy` and `done` are 0. `latch_stb` is 0, or 1 in the bypass variant.
- R2: A start seen while idle sends all `WORD_W = CH_PER_DEV*N_DEV` bits of `load_word`, bit `WORD_W-1` first and bit 0 last. Each bit is marked by exactly one `ser_clk` high pulse, and `ser_clk` stays low when not busy.
- R3: `ser_data` takes each new bit exactly `ceil(T_SETUP_NS/CLK_PERIOD_NS)` cycles before `ser_clk` rises.
- R4: `ser_clk` stays high for `ceil(T_HIGH_NS/CLK_PERIOD_NS)` cycles, and `ser_data` does not change while it is high.
- R5: After `ser_clk` falls, `ser_data` stays unchanged for `ceil(T_HOLD_NS/CLK_PERIOD_NS)` cycles plus one more cycle before the next bit appears.
- R6: `latch_stb` rises `ceil(T_HOLD_NS/..) + ceil(T_GAP_NS/..)` cycles after the last `ser_clk` fall.
- R7: `latch_stb` is high for exactly `ceil(T_STB_NS/CLK_PERIOD_NS)` cycles, once per frame, and never while `ser_clk` is high.
- R8: `done` is high for one cycle, in the cycle right after `latch_stb` falls. `busy` is high from the cycle after the start is accepted through the `done` cycle.
- R9: A start that arrives while `busy` is high, including during the `done` cycle, is ignored. It neither changes the waveform nor the word that is latched.
- R10: `blank_req` is sampled when a start is accepted. If it is set, `blank_out` is high during exactly the gap and strobe cycles of that frame. `blank_out` is otherwise low, and the latched word is unaffected.
- R11: In the bypass variant (`LATCH_BYPASS=1`), `latch_stb` is held at 1. `blank_out` is high from the first setup cycle to the end of the strobe phase, and the chain's shift stage holds the word when `done` pulses.
- R12: Cycle counts are derived by rounding up. Any timing, period or size parameter below 1 stops elaboration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request to load `load_word` |
| load_word | input | WORD_W | Word to send; bit WORD_W-1 goes first |
| blank_req | input | 1 | Blank the outputs around this frame's strobe |
| ser_clk | output | 1 | Serial clock to the driver chain |
| ser_data | output | 1 | Serial data to the driver chain |
| latch_stb | output | 1 | Latch strobe to the driver chain |
| blank_out | output | 1 | Blanking to the driver chain |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle frame-complete pulse |

## Verification
The bound checker watches several properties on every cycle. These are serial data holding steady across each clock-high phase and at the falling edge, the serial clock staying quiet outside a frame, and the strobe never overlapping a clock pulse. It also checks that done follows the strobe's fall as a single pulse that ends busy, that blanking occurs only within a frame, and the tied strobe of the bypass variant. The exact widths of setup, high, hold, gap and strobe can only be shown by the bench's per-cycle comparison against its behavioural waveform model. The same holds for MSB-first order, the arrival of the word at a modelled driver chain, and the discarding of starts during busy and done. The bench runs both build variants side by side.

// File: rtl/ldr_pkg.sv
package ldr_pkg;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_SETUP = 3'd1,
      ST_CLKH  = 3'd2,
      ST_HOLD  = 3'd3,
      ST_NEXT  = 3'd4,
      ST_GAP   = 3'd5,
      ST_STB   = 3'd6,
      ST_DONE  = 3'd7
   } ldr_state_t;

   function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned per);
      return (ns + per - 1) / per;
   endfunction

   function automatic int unsigned max2(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/ldr_timer.sv
module ldr_timer #(
   parameter int unsigned TW = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ld,
   input  logic [TW-1:0] ld_val,
   output logic          tz
);
   logic [TW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           cnt <= '0;
      else if (ld)          cnt <= ld_val;
      else if (cnt != '0)   cnt <= cnt - 1'b1;
   end

   assign tz = (cnt == '0);
endmodule

// File: rtl/ldr_shifter.sv
module ldr_shifter #(
   parameter int unsigned WORD_W = 20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              shift,
   input  logic [WORD_W-1:0] word,
   output logic              msb
);
   logic [WORD_W-1:0] sreg;

   generate
      if (WORD_W == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     sreg <= '0;
            else if (load)  sreg <= word;
         end
         logic unused_shift;
         assign unused_shift = shift;
      end else begin : g_multi
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      sreg <= '0;
            else if (load)   sreg <= word;
            else if (shift)  sreg <= {sreg[WORD_W-2:0], 1'b0};
         end
      end
   endgenerate

   assign msb = sreg[WORD_W-1];
endmodule

// File: rtl/ldr_fsm.sv
module ldr_fsm
   import ldr_pkg::*;
#(
   parameter int unsigned WORD_W = 20,
   parameter int unsigned TW     = 3,
   parameter int unsigned C_SU   = 2,
   parameter int unsigned C_HI   = 3,
   parameter int unsigned C_HO   = 2,
   parameter int unsigned C_GAP  = 5,
   parameter int unsigned C_ST   = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          blank_req,
   input  logic          tz,
   output logic          ld,
   output logic [TW-1:0] ld_val,
   output logic          sh_load,
   output logic          sh_en,
   output logic          blank_arm,
   output ldr_state_t    state_n
);
   localparam int unsigned BW = (WORD_W > 1) ? $clog2(WORD_W) : 1;
   localparam logic [TW-1:0] V_SU  = TW'(C_SU - 1);
   localparam logic [TW-1:0] V_HI  = TW'(C_HI - 1);
   localparam logic [TW-1:0] V_HO  = TW'(C_HO - 1);
   localparam logic [TW-1:0] V_GAP = TW'(C_GAP - 1);
   localparam logic [TW-1:0] V_ST  = TW'(C_ST - 1);
   localparam logic [BW-1:0] LAST  = BW'(WORD_W - 1);

   ldr_state_t    state;
   logic [BW-1:0] bits_left;

   always_comb begin
      state_n = state;
      ld      = 1'b0;
      ld_val  = '0;
      sh_load = 1'b0;
      sh_en   = 1'b0;
      unique case (state)
         ST_IDLE:  if (start) begin
                      state_n = ST_SETUP; ld = 1'b1; ld_val = V_SU; sh_load = 1'b1;
                   end
         ST_SETUP: if (tz) begin state_n = ST_CLKH; ld = 1'b1; ld_val = V_HI; end
         ST_CLKH:  if (tz) begin state_n = ST_HOLD; ld = 1'b1; ld_val = V_HO; end
         ST_HOLD:  if (tz) begin
                      if (bits_left == '0) begin
                         state_n = ST_GAP; ld = 1'b1; ld_val = V_GAP;
                      end else begin
                         state_n = ST_NEXT;
                      end
                   end
         ST_NEXT:  begin state_n = ST_SETUP; ld = 1'b1; ld_val = V_SU; sh_en = 1'b1; end
         ST_GAP:   if (tz) begin state_n = ST_STB; ld = 1'b1; ld_val = V_ST; end
         ST_STB:   if (tz) state_n = ST_DONE;
         ST_DONE:  state_n = ST_IDLE;
         default:  state_n = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         bits_left <= '0;
         blank_arm <= 1'b0;
      end else begin
         state <= state_n;
         if (sh_load) begin
            bits_left <= LAST;
            blank_arm <= blank_req;
         end else if (sh_en) begin
            bits_left <= bits_left - 1'b1;
         end
      end
   end
endmodule

// File: rtl/ldr_pins.sv
module ldr_pins
   import ldr_pkg::*;
#(
   parameter bit LATCH_BYPASS = 1'b0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  ldr_state_t state_n,
   input  logic       blank_arm,
   output logic       ser_clk,
   output logic       latch_stb,
   output logic       blank_out,
   output logic       busy,
   output logic       done
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ser_clk <= 1'b0;
         busy    <= 1'b0;
         done    <= 1'b0;
      end else begin
         ser_clk <= (state_n == ST_CLKH);
         busy    <= (state_n != ST_IDLE);
         done    <= (state_n == ST_DONE);
      end
   end

   generate
      if (LATCH_BYPASS) begin : g_bypass
         logic unused_arm;
         assign unused_arm = blank_arm;
         assign latch_stb  = 1'b1;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) blank_out <= 1'b0;
            else        blank_out <= (state_n != ST_IDLE) && (state_n != ST_DONE);
         end
      end else begin : g_latched
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               latch_stb <= 1'b0;
               blank_out <= 1'b0;
            end else begin
               latch_stb <= (state_n == ST_STB);
               blank_out <= blank_arm && ((state_n == ST_GAP) || (state_n == ST_STB));
            end
         end
      end
   endgenerate
endmodule

// File: rtl/serial_drv_loader.sv
module serial_drv_loader
   import ldr_pkg::*;
#(
   parameter int unsigned CH_PER_DEV    = 10,
   parameter int unsigned N_DEV         = 2,
   parameter int unsigned CLK_PERIOD_NS = 20,
   parameter int unsigned T_SETUP_NS    = 25,
   parameter int unsigned T_HIGH_NS     = 50,
   parameter int unsigned T_HOLD_NS     = 25,
   parameter int unsigned T_GAP_NS      = 100,
   parameter int unsigned T_STB_NS      = 50,
   parameter bit          LATCH_BYPASS  = 1'b0,
   localparam int unsigned WORD_W       = CH_PER_DEV * N_DEV
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [WORD_W-1:0] load_word,
   input  logic              blank_req,
   output logic              ser_clk,
   output logic              ser_data,
   output logic              latch_stb,
   output logic              blank_out,
   output logic              busy,
   output logic              done
);
   localparam int unsigned C_SU  = ns_to_cyc(T_SETUP_NS, CLK_PERIOD_NS);
   localparam int unsigned C_HI  = ns_to_cyc(T_HIGH_NS,  CLK_PERIOD_NS);
   localparam int unsigned C_HO  = ns_to_cyc(T_HOLD_NS,  CLK_PERIOD_NS);
   localparam int unsigned C_GAP = ns_to_cyc(T_GAP_NS,   CLK_PERIOD_NS);
   localparam int unsigned C_ST  = ns_to_cyc(T_STB_NS,   CLK_PERIOD_NS);
   localparam int unsigned C_MAX = max2(max2(max2(C_SU, C_HI), max2(C_HO, C_GAP)), C_ST);
   localparam int unsigned TW    = $clog2(C_MAX + 1);

   // R12: reject parameter sets that would give zero-length phases
   if (CLK_PERIOD_NS < 1) begin : g_bad_period
      $error("CLK_PERIOD_NS must be at least 1");
   end
   if (CH_PER_DEV < 1 || N_DEV < 1) begin : g_bad_size
      $error("CH_PER_DEV and N_DEV must be at least 1");
   end
   if (T_SETUP_NS < 1 || T_HIGH_NS < 1 || T_HOLD_NS < 1 || T_GAP_NS < 1 || T_STB_NS < 1) begin : g_bad_time
      $error("every timing parameter must be at least 1 ns");
   end

   logic          ld, tz, sh_load, sh_en, blank_arm;
   logic [TW-1:0] ld_val;
   ldr_state_t    state_n;

   ldr_timer #(.TW(TW)) u_timer (
      .clk(clk), .rst_n(rst_n), .ld(ld), .ld_val(ld_val), .tz(tz)
   );

   ldr_fsm #(
      .WORD_W(WORD_W), .TW(TW), .C_SU(C_SU), .C_HI(C_HI),
      .C_HO(C_HO), .C_GAP(C_GAP), .C_ST(C_ST)
   ) u_fsm (
      .clk(clk), .rst_n(rst_n), .start(start), .blank_req(blank_req), .tz(tz),
      .ld(ld), .ld_val(ld_val), .sh_load(sh_load), .sh_en(sh_en),
      .blank_arm(blank_arm), .state_n(state_n)
   );

   ldr_shifter #(.WORD_W(WORD_W)) u_shift (
      .clk(clk), .rst_n(rst_n), .load(sh_load), .shift(sh_en),
      .word(load_word), .msb(ser_data)
   );

   ldr_pins #(.LATCH_BYPASS(LATCH_BYPASS)) u_pins (
      .clk(clk), .rst_n(rst_n), .state_n(state_n), .blank_arm(blank_arm),
      .ser_clk(ser_clk), .latch_stb(latch_stb), .blank_out(blank_out),
      .busy(busy), .done(done)
   );
endmodule

// File: rtl/ldr_checker.sv
module ldr_checker #(
   parameter bit LATCH_BYPASS = 1'b0
) (
   input logic clk,
   input logic rst_n,
   input logic ser_clk,
   input logic ser_data,
   input logic latch_stb,
   input logic blank_out,
   input logic busy,
   input logic done
);
   p_clk_quiet_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !ser_clk);
   p_data_steady_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ser_clk |-> $stable(ser_data));
   p_data_held_at_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ser_clk) |-> $stable(ser_data));
   p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   p_done_ends_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !busy);
   p_busy_no_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !done) |=> busy);
   p_blank_in_frame_r10: assert property (@(posedge clk) disable iff (!rst_n)
      blank_out |-> busy);

   generate
      if (LATCH_BYPASS) begin : g_byp
         p_stb_tied_r11: assert property (@(posedge clk) disable iff (!rst_n)
            latch_stb);
         p_blank_cover_r11: assert property (@(posedge clk) disable iff (!rst_n)
            ser_clk |-> blank_out);
      end else begin : g_lat
         p_stb_no_clk_r7: assert property (@(posedge clk) disable iff (!rst_n)
            latch_stb |-> !ser_clk);
         p_done_after_stb_r8: assert property (@(posedge clk) disable iff (!rst_n)
            done |-> $fell(latch_stb));
      end
   endgenerate
endmodule

bind serial_drv_loader ldr_checker #(.LATCH_BYPASS(LATCH_BYPASS)) u_ldr_chk (
   .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
   .latch_stb(latch_stb), .blank_out(blank_out), .busy(busy), .done(done)
);

// File: tb/tb_serial_drv_loader.sv
module tb_serial_drv_loader;
   localparam int W   = 20;
   localparam int PER = 20;
   localparam int SU  = (25  + PER - 1) / PER;
   localparam int HI  = (50  + PER - 1) / PER;
   localparam int HO  = (25  + PER - 1) / PER;
   localparam int GP  = (100 + PER - 1) / PER;
   localparam int ST  = (50  + PER - 1) / PER;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic blank_req = 1'b0;
   logic [W-1:0] load_word = '0;
   always #10 clk = ~clk;

   logic n_sclk, n_sdat, n_stb, n_blk, n_busy, n_done;
   logic b_sclk, b_sdat, b_stb, b_blk, b_busy, b_done;

   serial_drv_loader #(.CH_PER_DEV(10), .N_DEV(2), .LATCH_BYPASS(1'b0)) dut (
      .clk(clk), .rst_n(rst_n), .start(start), .load_word(load_word), .blank_req(blank_req),
      .ser_clk(n_sclk), .ser_data(n_sdat), .latch_stb(n_stb), .blank_out(n_blk),
      .busy(n_busy), .done(n_done));

   serial_drv_loader #(.CH_PER_DEV(10), .N_DEV(2), .LATCH_BYPASS(1'b1)) dut_byp (
      .clk(clk), .rst_n(rst_n), .start(start), .load_word(load_word), .blank_req(blank_req),
      .ser_clk(b_sclk), .ser_data(b_sdat), .latch_stb(b_stb), .blank_out(b_blk),
      .busy(b_busy), .done(b_done));

   int checks = 0;
   int failures = 0;
   bit finished = 1'b0;

   task automatic chk(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s at %0t: actual=%b expected=%b", req, $time, act, exp);
      end
   endtask

   task automatic chkw(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s at %0t: actual=%h expected=%h", req, $time, act, exp);
      end
   endtask

   // reference model: vectors {sclk,sdata,strobe,blank,busy,done}, latched | bypass
   logic [11:0] q[$];
   logic [11:0] cur;
   logic        last_bit;

   function automatic logic [11:0] vec(input logic sc, input logic sd, input int ph, input logic ben);
      // ph: 0 shift, 1 gap, 2 strobe, 3 done, 4 idle
      logic [5:0] n, b;
      logic bz, dn;
      bz = (ph != 4) && (ph != 3) ? 1'b1 : (ph == 3);
      dn = (ph == 3);
      n = {sc, sd, ph == 2, ben && (ph == 1 || ph == 2), ph != 4, dn};
      b = {sc, sd, 1'b1, ph <= 2, ph != 4, dn};
      if (!bz) n[1] = 1'b0;
      return {n, b};
   endfunction

   task automatic push_frame(input logic [W-1:0] w, input logic ben);
      for (int i = W - 1; i >= 0; i--) begin
         for (int k = 0; k < SU; k++) q.push_back(vec(1'b0, w[i], 0, ben));
         for (int k = 0; k < HI; k++) q.push_back(vec(1'b1, w[i], 0, ben));
         for (int k = 0; k < HO; k++) q.push_back(vec(1'b0, w[i], 0, ben));
         if (i > 0) q.push_back(vec(1'b0, w[i], 0, ben));
      end
      for (int k = 0; k < GP; k++) q.push_back(vec(1'b0, w[0], 1, ben));
      for (int k = 0; k < ST; k++) q.push_back(vec(1'b0, w[0], 2, ben));
      q.push_back(vec(1'b0, w[0], 3, ben));
   endtask

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q.delete();
         last_bit = 1'b0;
         cur = vec(1'b0, 1'b0, 4, 1'b0);
      end else if (q.size() != 0) begin
         cur = q.pop_front();
      end else if (cur[7] == 1'b0 && start) begin
         push_frame(load_word, blank_req);
         last_bit = load_word[0];
         cur = q.pop_front();
      end else begin
         cur = vec(1'b0, last_bit, 4, 1'b0);
      end
   end

   // driver-chain models
   logic [W-1:0] n_sr = '0, n_lat = '0, b_sr = '0, want_word = '0;
   logic n_psc = 1'b0, b_psc = 1'b0;

   always @(negedge clk) begin
      if (rst_n && !finished) begin
         chk("R2/R4 sclk latched", n_sclk, cur[11]);
         chk("R3/R5/R12 sdata latched", n_sdat, cur[10]);
         chk("R6/R7 strobe latched", n_stb, cur[9]);
         chk("R10 blank latched", n_blk, cur[8]);
         chk("R8 busy latched", n_busy, cur[7]);
         chk("R8 done latched", n_done, cur[6]);
         chk("R11 sclk bypass", b_sclk, cur[5]);
         chk("R11 sdata bypass", b_sdat, cur[4]);
         chk("R11 strobe bypass", b_stb, cur[3]);
         chk("R11 blank bypass", b_blk, cur[2]);
         chk("R11 busy bypass", b_busy, cur[1]);
         chk("R11 done bypass", b_done, cur[0]);
         if (n_sclk && !n_psc) n_sr = {n_sr[W-2:0], n_sdat};
         if (b_sclk && !b_psc) b_sr = {b_sr[W-2:0], b_sdat};
         if (n_stb) n_lat = n_sr;
         if (n_done) chkw("R2/R9 latched chain word", n_lat, want_word);
         if (b_done) chkw("R11 bypass chain word", b_sr, want_word);
         n_psc = n_sclk;
         b_psc = b_sclk;
      end
   end

   task automatic send(input logic [W-1:0] w, input logic ben);
      @(negedge clk);
      load_word = w; blank_req = ben; start = 1'b1; want_word = w;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic wait_idle;
      @(negedge clk);
      while (n_busy) @(negedge clk);
      @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state
      chk("R1 sclk", n_sclk, 1'b0);
      chk("R1 sdata", n_sdat, 1'b0);
      chk("R1 strobe", n_stb, 1'b0);
      chk("R1 strobe bypass", b_stb, 1'b1);
      chk("R1 blank", n_blk, 1'b0);
      chk("R1 busy", n_busy, 1'b0);
      chk("R1 done", n_done, 1'b0);
      repeat (3) @(negedge clk);
      // R2/R3/R4/R5/R6/R7: mixed word, no blanking
      send(20'hA5C3F, 1'b0); wait_idle();
      // R10: blanking requested
      send(20'hFFFFF, 1'b1); wait_idle();
      // boundary words: only LSB, only MSB
      send(20'h00001, 1'b1); wait_idle();
      send(20'h80000, 1'b0);
      // R9: starts during busy and during done must be ignored
      repeat (40) @(negedge clk);
      load_word = 20'h12345; blank_req = 1'b1; start = 1'b1;
      @(negedge clk); start = 1'b0;
      while (!n_done) @(negedge clk);
      load_word = 20'h0F0F0; start = 1'b1;
      @(negedge clk); start = 1'b0;
      repeat (3) @(negedge clk);
      chk("R9 no restart after done", n_busy, 1'b0);
      chkw("R9 latch kept", n_lat, 20'h80000);
      // back-to-back frame right after idle
      send(20'h5A5A5, 1'b0); wait_idle();
      if (!finished) begin
         finished = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         checks++;
         failures++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule